// File: doc/BRIEF.md
# Control Signal Pulse Filter

This block conditions three slow control lines (data enable, horizontal sync and vertical sync) on their way into a serial link framer. It runs on the pixel clock. A two-bit mode input selects either a minimum-width glitch filter or a plain pass-through. Both paths have the same fixed latency, so the control lines stay aligned with pixel data that is delayed by a matching pipeline.

Alongside the data path, a monitor watches how often each forwarded control line changes level. The data-enable and horizontal-sync lines may change at most twice in any span of 130 consecutive clocks. The vertical-sync line may change at most once in that span. A change beyond a line's allowance sets a sticky flag for that line. The change itself is still forwarded. An active-low power-down input clears every register in the block, including the change history.

Top module: `ctl_pulse_cond`

## Requirements
- R1: While `pwr_n` is low, `ctl_out` and `viol_flag` are all zero, and all internal state (mode register, filter history and change history) is cleared.
- R2: The mode is captured in a register on each clock, and the captured value takes effect from that clock edge. Code 2'b01 selects the filter. Codes 2'b00, 2'b10 and 2'b11 all select pass-through.
- R3: In pass-through, `ctl_out` after a clock edge k+2 equals `ctl_in` as sampled at edge k, for every level pattern including single-cycle pulses.
- R4: In filter mode, a line's output takes a new level only after that level has been sampled on 3 consecutive edges, and it shows the new level right after the third of those edges. Runs of 1 or 2 samples are dropped and the output keeps its previous level.
- R5: The bit positions are fixed: bit 0 is data enable, bit 1 is horizontal sync and bit 2 is vertical sync. Each bit is filtered and monitored on its own; activity on one bit leaves the other bits' outputs and flags untouched.
- R6: On bits 0 and 1, a third output change is a violation when it comes 129 or fewer clocks after the first of the three. If it comes 130 clocks after the first, it is not a violation.
- R7: On bit 2, a second output change is a violation when it comes 129 or fewer clocks after the previous change. A spacing of 130 clocks is legal.
- R8: A violation sets that bit of `viol_flag` one clock after the output change. The flag then stays set. The change that caused it is still forwarded on `ctl_out`.
- R9: `viol_clr` high at a clock edge clears all flags at that edge. If a violation is detected at the same edge, the set takes priority over the clear.
- R10: After power-down is released, the change history starts empty, so changes made before power-down do not count toward any allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| pwr_n | input | 1 | Active-low power-down; asynchronous clear of all state |
| mode | input | 2 | 01 = filter, any other code = pass-through |
| viol_clr | input | 1 | Clears the sticky violation flags |
| ctl_in | input | 3 | Raw control lines: bit 0 data enable, bit 1 hsync, bit 2 vsync |
| ctl_out | output | 3 | Conditioned control lines, same bit order |
| viol_flag | output | 3 | Sticky per-line change-rate violation flags |

## Verification
The bench drives pulses of width 1, 2 and 3 in filter mode and checks the exact clock on which a width-3 pulse appears. An off-by-one filter would either pass 2-cycle glitches or drop legal 3-cycle pulses, and a wrong latency would shift the output by one clock against the pass-through path. Change spacings of exactly 129 and 130 clocks are driven on a fast line and on the vertical-sync line. A monitor with a wrong window edge, a mishandled timestamp wrap, or the fast allowance applied to vertical sync would flag the wrong case. Further cases cover a clear in the same cycle as a violation, and a power-down between changes; a design that lets the clear win, or keeps stale history, would show a wrong flag.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

   typedef enum logic [1:0] {
      CPF_MODE_PASS     = 2'b00,
      CPF_MODE_FILTER   = 2'b01,
      CPF_MODE_LEGACY_A = 2'b10,
      CPF_MODE_LEGACY_B = 2'b11
   } cpf_mode_e;

   localparam int CPF_CH_DE  = 0;
   localparam int CPF_CH_HS  = 1;
   localparam int CPF_CH_VS  = 2;
   localparam int CPF_NUM_CH = 3;

endpackage

// File: rtl/cpf_sync_filter.sv
// One control line: sample history, minimum-run glitch filter, and a
// pass-through tap taken at the same depth so both paths share one latency.
module cpf_sync_filter #(
   parameter int MIN_RUN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic filt_en,
   input  logic din,
   output logic dout
);

   logic [MIN_RUN-1:0] hist;     // hist[0] holds the newest sample
   logic               held;
   logic               agree;
   logic               filt_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         held <= 1'b0;
      end else begin
         hist <= {hist[MIN_RUN-2:0], din};
         held <= filt_v;
      end
   end

   assign agree  = (&hist) | ~(|hist);
   assign filt_v = agree ? hist[0] : held;
   assign dout   = filt_en ? filt_v : hist[MIN_RUN-1];

endmodule

// File: rtl/cpf_rate_monitor.sv
// Change-rate monitor for one line. It keeps the stamps of the last BUDGET
// changes, taken from a shared wrapping counter; an entry expires once its
// age reaches WINDOW, before the counter can alias.
module cpf_rate_monitor #(
   parameter int WINDOW = 130,
   parameter int BUDGET = 2,
   parameter int CW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] now,
   input  logic          sig,
   input  logic          clr,
   output logic          flag
);

   logic [CW-1:0]     stamp [BUDGET];
   logic [CW-1:0]     age   [BUDGET];
   logic [BUDGET-1:0] valid;
   logic [BUDGET-1:0] live;
   logic              sig_q;
   logic              chg;
   logic              over;

   for (genvar j = 0; j < BUDGET; j++) begin : g_age
      assign age[j]  = now - stamp[j];
      assign live[j] = valid[j] && (age[j] < CW'(WINDOW));
   end

   assign chg  = sig ^ sig_q;
   // Entries fill from the newest end, so all live means the allowance is used up.
   assign over = chg && (&live);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < BUDGET; j++) stamp[j] <= '0;
         valid <= '0;
         sig_q <= 1'b0;
         flag  <= 1'b0;
      end else begin
         sig_q <= sig;
         flag  <= over | (flag & ~clr);
         if (chg) begin
            stamp[0] <= now;
            valid[0] <= 1'b1;
            for (int j = 1; j < BUDGET; j++) begin
               stamp[j] <= stamp[j-1];
               valid[j] <= live[j-1];
            end
         end else begin
            valid <= live;
         end
      end
   end

endmodule

// File: rtl/ctl_pulse_cond.sv
module ctl_pulse_cond #(
   parameter int N_CH        = cpf_pkg::CPF_NUM_CH,
   parameter int MIN_RUN     = 3,
   parameter int WINDOW      = 130,
   parameter int FAST_BUDGET = 2,
   parameter int SLOW_BUDGET = 1,
   parameter int SLOW_CH     = cpf_pkg::CPF_CH_VS
) (
   input  logic            clk,
   input  logic            pwr_n,
   input  logic [1:0]      mode,
   input  logic            viol_clr,
   input  logic [N_CH-1:0] ctl_in,
   output logic [N_CH-1:0] ctl_out,
   output logic [N_CH-1:0] viol_flag
);
   import cpf_pkg::*;

   localparam int CW = $clog2(WINDOW + 1);

   if (MIN_RUN < 2) begin : g_bad_run
      $error("MIN_RUN must be at least 2");
   end
   if (FAST_BUDGET < 1 || SLOW_BUDGET < 1) begin : g_bad_budget
      $error("budgets must be at least 1");
   end
   if (SLOW_CH < 0 || SLOW_CH >= N_CH) begin : g_bad_slow
      $error("SLOW_CH out of range");
   end
   if (WINDOW < 2) begin : g_bad_window
      $error("WINDOW too small");
   end

   cpf_mode_e     mode_q;
   logic          filt_en;
   logic [CW-1:0] tick;

   always_ff @(posedge clk or negedge pwr_n) begin
      if (!pwr_n) begin
         mode_q <= CPF_MODE_PASS;
         tick   <= '0;
      end else begin
         mode_q <= cpf_mode_e'(mode);
         tick   <= tick + 1'b1;
      end
   end

   assign filt_en = (mode_q == CPF_MODE_FILTER);

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int BUD = (c == SLOW_CH) ? SLOW_BUDGET : FAST_BUDGET;

      cpf_sync_filter #(.MIN_RUN(MIN_RUN)) u_filt (
         .clk     (clk),
         .rst_n   (pwr_n),
         .filt_en (filt_en),
         .din     (ctl_in[c]),
         .dout    (ctl_out[c])
      );

      cpf_rate_monitor #(.WINDOW(WINDOW), .BUDGET(BUD), .CW(CW)) u_mon (
         .clk   (clk),
         .rst_n (pwr_n),
         .now   (tick),
         .sig   (ctl_out[c]),
         .clr   (viol_clr),
         .flag  (viol_flag[c])
      );
   end

endmodule

// File: rtl/ctl_pulse_cond_chk.sv
module ctl_pulse_cond_chk #(
   parameter int N_CH    = 3,
   parameter int MIN_RUN = 3
) (
   input logic            clk,
   input logic            pwr_n,
   input logic [1:0]      mode,
   input logic            viol_clr,
   input logic [N_CH-1:0] ctl_in,
   input logic [N_CH-1:0] ctl_out,
   input logic [N_CH-1:0] viol_flag
);

   // R1: outputs quiet while powered down
   a_r1_pd_quiet: assert property (@(posedge clk)
      !pwr_n |-> (ctl_out == '0 && viol_flag == '0));

   // R8: a flag never drops without a clear
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!pwr_n)
      !viol_clr |=> ((viol_flag & $past(viol_flag)) == $past(viol_flag)));

   // R8: a newly set flag follows an output change on the same line
   a_r8_set_cause: assert property (@(posedge clk) disable iff (!pwr_n)
      $past(pwr_n, 2) |->
      ((viol_flag & ~$past(viol_flag) & ~($past(ctl_out) ^ $past(ctl_out, 2))) == '0));

   // R9: a clear with no output change leaves every flag low
   a_r9_clear: assert property (@(posedge clk) disable iff (!pwr_n)
      (viol_clr && ctl_out == $past(ctl_out)) |=> (viol_flag == '0));

   if (MIN_RUN == 3) begin : g_lat3
      // R3: pass-through is a pure three-clock delay
      a_r3_bypass_delay: assert property (@(posedge clk) disable iff (!pwr_n)
         ($past(mode) != 2'b01 && $past(pwr_n) && $past(pwr_n, 2) && $past(pwr_n, 3))
         |-> (ctl_out == $past(ctl_in, 3)));

      // R4: in filter mode a changed bit was sampled three times at its new level
      a_r4_min_width: assert property (@(posedge clk) disable iff (!pwr_n)
         ($past(mode) == 2'b01 && $past(mode, 2) == 2'b01 &&
          $past(pwr_n) && $past(pwr_n, 2) && $past(pwr_n, 3))
         |-> (((ctl_out ^ $past(ctl_out)) &
               (($past(ctl_in) ^ ctl_out) | ($past(ctl_in, 2) ^ ctl_out) |
                ($past(ctl_in, 3) ^ ctl_out))) == '0));
   end

endmodule

bind ctl_pulse_cond ctl_pulse_cond_chk #(.N_CH(N_CH), .MIN_RUN(MIN_RUN)) u_chk (
   .clk       (clk),
   .pwr_n     (pwr_n),
   .mode      (mode),
   .viol_clr  (viol_clr),
   .ctl_in    (ctl_in),
   .ctl_out   (ctl_out),
   .viol_flag (viol_flag)
);

// File: tb/ctl_pulse_cond_tb_top.sv
`timescale 1ns/1ps
module ctl_pulse_cond_tb_top;

   localparam int WIN = 130;

   logic       clk = 1'b0;
   logic       pwr_n = 1'b0;
   logic       viol_clr = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [2:0] ctl_in = 3'b000;
   logic [2:0] ctl_out;
   logic [2:0] viol_flag;

   always #2.5 clk = ~clk;

   ctl_pulse_cond dut_i (
      .clk       (clk),
      .pwr_n     (pwr_n),
      .mode      (mode),
      .viol_clr  (viol_clr),
      .ctl_in    (ctl_in),
      .ctl_out   (ctl_out),
      .viol_flag (viol_flag)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model state: values expected after the next clock edge
   logic [2:0] m_s0 = 0, m_s1 = 0, m_s2 = 0, m_filt = 0;
   logic [2:0] m_out = 0, m_prev = 0, m_flag = 0;
   int         e = 0;
   int         ht [3][2];
   int         hn [3] = '{0, 0, 0};

   logic [2:0] cur = 0;
   logic [1:0] cur_mode = 0;

   function automatic int budget_of(int ch);
      return (ch == 2) ? 1 : 2;
   endfunction

   function automatic logic [2:0] agree_mask(logic [2:0] a, logic [2:0] b, logic [2:0] c);
      return ~((a ^ b) | (b ^ c));
   endfunction

   task automatic check(string tag, string what, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic model_edge(logic [2:0] din, logic [1:0] md, logic cl, logic pw);
      logic [2:0] viol;
      logic [2:0] ag;
      if (!pw) begin
         m_s0 = 0; m_s1 = 0; m_s2 = 0; m_filt = 0;
         m_out = 0; m_prev = 0; m_flag = 0;
         hn = '{0, 0, 0};
      end else begin
         e++;
         viol = 0;
         for (int ch = 0; ch < 3; ch++) begin
            if (m_out[ch] != m_prev[ch]) begin
               int recent = 0;
               for (int k = 0; k < hn[ch]; k++)
                  if (e - ht[ch][k] <= WIN - 1) recent++;
               if (recent >= budget_of(ch)) viol[ch] = 1'b1;
               ht[ch][1] = ht[ch][0];
               ht[ch][0] = e;
               if (hn[ch] < 2) hn[ch]++;
            end
         end
         m_flag = viol | (m_flag & ~{3{cl}});
         m_prev = m_out;
         m_s2 = m_s1; m_s1 = m_s0; m_s0 = din;
         ag = agree_mask(m_s0, m_s1, m_s2);
         m_filt = (ag & m_s0) | (~ag & m_filt);
         m_out = (md == 2'b01) ? m_filt : m_s2;
      end
   endtask

   task automatic step(logic [2:0] din, logic [1:0] md, logic cl, logic pw, string tag);
      @(negedge clk);
      check(tag, "ctl_out", ctl_out, m_out);
      check(tag, "viol_flag", viol_flag, m_flag);
      ctl_in = din; mode = md; viol_clr = cl; pwr_n = pw;
      model_edge(din, md, cl, pw);
   endtask

   task automatic hold(int n, string tag);
      repeat (n) step(cur, cur_mode, 1'b0, 1'b1, tag);
   endtask

   task automatic power_cycle(string tag);
      cur = 0;
      repeat (3) step(cur, cur_mode, 1'b0, 1'b0, tag);
   endtask

   task automatic rand_runs(int n, int maxrun, string tag);
      for (int i = 0; i < n; i++) begin
         cur = 3'($urandom);
         hold(1 + int'($urandom % maxrun), tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4217));

      // R1: power-down holds everything low while inputs move
      for (int i = 0; i < 6; i++) step(3'($urandom), 2'b01, 1'b0, 1'b0, "R1");
      check("R1", "ctl_out in power-down", ctl_out, 3'b000);
      check("R1", "viol_flag in power-down", viol_flag, 3'b000);

      // R3: pass-through latency, directed then random
      cur_mode = 2'b00;
      hold(4, "R3");
      cur = 3'b001; hold(3, "R3");
      check("R3", "bypass before third edge", ctl_out, 3'b000);
      hold(1, "R3");
      check("R3", "bypass after third edge", ctl_out, 3'b001);
      cur = 3'b000; hold(1, "R3");
      for (int i = 0; i < 60; i++) begin cur = 3'($urandom); hold(1, "R3"); end

      // R2: legacy codes behave as pass-through, mode switching on the fly
      power_cycle("R2");
      cur_mode = 2'b10; rand_runs(20, 2, "R2");
      cur_mode = 2'b11; rand_runs(20, 2, "R2");
      cur_mode = 2'b01; rand_runs(20, 3, "R2");
      cur_mode = 2'b00; rand_runs(10, 3, "R2");

      // R4: filter widths 1, 2 and 3
      power_cycle("R4");
      cur_mode = 2'b01;
      hold(4, "R4");
      cur[0] = 1'b1; hold(1, "R4"); cur[0] = 1'b0; hold(5, "R4");
      check("R4", "width-1 pulse removed", ctl_out, 3'b000);
      cur[0] = 1'b1; hold(2, "R4"); cur[0] = 1'b0; hold(5, "R4");
      check("R4", "width-2 pulse removed", ctl_out, 3'b000);
      cur[0] = 1'b1; hold(3, "R4");
      check("R4", "width-3 before third edge", ctl_out, 3'b000);
      hold(1, "R4");
      check("R4", "width-3 passed", ctl_out, 3'b001);
      cur[0] = 1'b0; hold(6, "R4");
      rand_runs(80, 5, "R4");

      // R5: one line active, others stay put
      power_cycle("R5");
      cur_mode = 2'b00;
      for (int i = 0; i < 40; i++) begin cur = {1'b0, 1'($urandom), 1'b0}; hold(1, "R5"); end
      check("R5", "quiet lines stay low", ctl_out & 3'b101, 3'b000);
      check("R5", "quiet line flags stay low", viol_flag & 3'b101, 3'b000);

      // R6: fast line, third change at 129 clocks -> violation
      power_cycle("R6");
      cur[0] = 1'b1; hold(60, "R6");
      cur[0] = 1'b0; hold(69, "R6");
      cur[0] = 1'b1; hold(6, "R6");
      check("R6", "flag at 129 clocks", viol_flag, 3'b001);
      // R8: sticky and change forwarded
      hold(150, "R8");
      check("R8", "flag still set", viol_flag, 3'b001);
      check("R8", "violating change forwarded", ctl_out, 3'b001);
      // R9: clear with no change
      step(cur, cur_mode, 1'b1, 1'b1, "R9");
      hold(2, "R9");
      check("R9", "flags cleared", viol_flag, 3'b000);

      // R6: third change at 130 clocks -> legal
      power_cycle("R6");
      cur[1] = 1'b1; hold(65, "R6");
      cur[1] = 1'b0; hold(65, "R6");
      cur[1] = 1'b1; hold(6, "R6");
      check("R6", "no flag at 130 clocks", viol_flag, 3'b000);

      // R7: vsync, second change at 129 -> violation, at 130 -> legal
      power_cycle("R7");
      cur[2] = 1'b1; hold(129, "R7");
      cur[2] = 1'b0; hold(6, "R7");
      check("R7", "vsync flag at 129 clocks", viol_flag, 3'b100);
      power_cycle("R7");
      cur[2] = 1'b1; hold(130, "R7");
      cur[2] = 1'b0; hold(6, "R7");
      check("R7", "vsync no flag at 130 clocks", viol_flag, 3'b000);

      // R9: clear in the same cycle as a violation, set wins
      power_cycle("R9");
      cur[0] = 1'b1; hold(3, "R9");
      cur[0] = 1'b0; hold(3, "R9");
      cur[0] = 1'b1;
      hold(3, "R9");
      step(cur, cur_mode, 1'b1, 1'b1, "R9");
      hold(3, "R9");
      check("R9", "set beats clear", viol_flag, 3'b001);

      // R10: history is forgotten across power-down
      power_cycle("R10");
      cur[0] = 1'b1; hold(4, "R10");
      cur[0] = 1'b0; hold(6, "R10");
      power_cycle("R10");
      cur[0] = 1'b1; hold(4, "R10");
      cur[0] = 1'b0; hold(6, "R10");
      check("R10", "no flag after power-down", viol_flag, 3'b000);

      // mixed soak: long runs, random modes, occasional clears
      power_cycle("R8");
      for (int i = 0; i < 60; i++) begin
         cur_mode = 2'($urandom);
         cur = 3'($urandom);
         step(cur, cur_mode, 1'($urandom % 8 == 0), 1'b1, "R8");
         hold(1 + int'($urandom % 40), "R8");
      end
      hold(4, "R8");

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule